// File: doc/BRIEF.md
# Stop-Mode Standby Controller

This block decides when a small microcontroller enters its low-power stop state and how it leaves it. While running, software programs a standby byte. Bits in that byte choose which oscillators may shut down and whether the covered output pins float or keep their last values. Stop is entered on request, but only when the system clock source is the main clock divided by two. A request made with any other source is dropped, and a sticky error flag records it.

While stopped, the block drives enables for the main and sub oscillators and their PLLs, and a pin-output control. It watches three kinds of clockless wake-up interrupt, each with a priority level, along with two reset requests. A qualified interrupt returns the part to RUN. If an oscillator was stopped, the return first passes through a stabilization wait of programmable length. A reset request sends the part to the matching reset state, whatever state it is in.

The interrupt controller, the analog oscillators and the PLL circuits sit outside this block. It only produces their enables and consumes their request lines.

Top module: `stop_ctl`

## Requirements
- R1: After rst_n is released, `state` is 0 (RUN) and `run` is 1. Both oscillator enables are 1, each PLL enable equals its select input, `pin_hiz` and `pin_hold` are 0, `cfg_err` is 0 and `stby_rd` is 8'h00.
- R2: In RUN, `stop_req` with `clk_sel` equal to 2'b00 (main clock divided by two) moves `state` to 1 (STOP) on the next cycle.
- R3: In RUN, `stop_req` with any other `clk_sel` value leaves `state` at RUN and sets `cfg_err`. Only an INIT request or rst_n clears `cfg_err`.
- R4: In STOP, `main_osc_en` is the inverse of standby bit 0 and `sub_osc_en` is the inverse of standby bit 1. In every other state both are 1.
- R5: In STOP, `main_pll_en` is 1 only when standby bit 0 is 0 and `main_pll_sel` is 1. `sub_pll_en` follows the same rule with standby bit 1 and `sub_pll_sel`. Outside STOP, each PLL enable equals its select input.
- R6: In STOP and WAKE (state 2), `pin_hiz` equals standby bit 5 and `pin_hold` is its inverse. In all other states both are 0.
- R7: In STOP, the part wakes on any of these, provided its level is not 5'h1F:
  - any external request;
  - the stabilization-timer interrupt, only while standby bit 0 is 0;
  - the watch interrupt, only while standby bit 1 is 0.
- R8: On a wake with standby bits 0 and 1 both 0, `state` returns to RUN on the next cycle. Otherwise the part spends `stab_cnt`+1 cycles in WAKE with both oscillators enabled and then enters RUN. The pin controls drop in the same cycle that RUN appears.
- R9: In any state, `init_req` moves the part to state 3 (INIT) on the next cycle. Otherwise `rst_req` moves it to state 4 (RST). Both take priority over interrupt wake-ups.
- R10: Entering INIT clears the standby byte and `cfg_err`, and entering RST keeps them. Each reset state is held while its request stays high and goes to RUN in the cycle after the request drops.
- R11: `stby_wr` loads `stby_wdata` into the standby byte only in RUN. Writes in any other state are ignored, as `stby_rd` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_wr | input | 1 | Standby byte write strobe |
| stby_wdata | input | 8 | Standby byte write data |
| stby_rd | output | 8 | Standby byte contents |
| main_pll_sel | input | 1 | Main PLL enable bit from the clock source register |
| sub_pll_sel | input | 1 | Sub PLL enable bit from the clock source register |
| clk_sel | input | 2 | Current clock source, 2'b00 = main clock / 2 |
| stop_req | input | 1 | Request to enter stop |
| stab_cnt | input | 8 | Stabilization wait length after wake |
| ext_irq | input | 4 | External interrupt requests |
| ext_lvl | input | 20 | Levels of the external requests, 5 bits each |
| stab_irq | input | 1 | Main oscillation-stabilization timer interrupt |
| stab_lvl | input | 5 | Level of stab_irq |
| watch_irq | input | 1 | Watch interrupt |
| watch_lvl | input | 5 | Level of watch_irq |
| init_req | input | 1 | Settings-initialization reset request |
| rst_req | input | 1 | Operation-initialization reset request |
| state | output | 3 | 0 RUN, 1 STOP, 2 WAKE, 3 INIT, 4 RST |
| run | output | 1 | High in RUN |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| main_pll_en | output | 1 | Main PLL enable |
| sub_pll_en | output | 1 | Sub PLL enable |
| pin_hiz | output | 1 | Float covered output pins |
| pin_hold | output | 1 | Hold covered output pins |
| cfg_err | output | 1 | Sticky stop-refused flag |

## Verification
The controller has a single registered state, so a wrong transition shows on `state` and on the enables decoded from it in the cycle after the causing input. A bench model tracks every cycle and compares all outputs each cycle. A miscounted stabilization wait shows as RUN arriving one or more cycles early or late. A wrongly qualified wake source shows as STOP being left, or not left, in the cycle after the request. A corrupted standby byte appears at once on `stby_rd` and, inside stop, on the oscillator and pin controls.

// File: rtl/stop_pkg.sv
package stop_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_STOP = 3'd1,
        ST_WAKE = 3'd2,
        ST_INIT = 3'd3,
        ST_RST  = 3'd4
    } pwr_state_e;

    localparam int STBY_W      = 8;
    localparam int BIT_MAIN_OFF = 0;
    localparam int BIT_SUB_OFF  = 1;
    localparam int BIT_FLOAT    = 5;
endpackage

// File: rtl/stop_wake_eval.sv
module stop_wake_eval #(
    parameter int N_EXT = 4,
    parameter int LW    = 5
) (
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic [N_EXT*LW-1:0] ext_lvl,
    input  logic                stab_irq,
    input  logic [LW-1:0]       stab_lvl,
    input  logic                watch_irq,
    input  logic [LW-1:0]       watch_lvl,
    input  logic                main_running,
    input  logic                sub_running,
    output logic                wake
);
    localparam logic [LW-1:0] LVL_OFF = {LW{1'b1}};

    logic [N_EXT-1:0] ext_ok;

    generate
        for (genvar i = 0; i < N_EXT; i++) begin : g_ext
            assign ext_ok[i] = ext_irq[i] && (ext_lvl[i*LW +: LW] != LVL_OFF);
        end
    endgenerate

    logic stab_ok;
    logic watch_ok;

    always_comb begin
        stab_ok  = stab_irq && main_running && (stab_lvl != LVL_OFF);
        watch_ok = watch_irq && sub_running && (watch_lvl != LVL_OFF);
        wake     = (|ext_ok) || stab_ok || watch_ok;
    end
endmodule

// File: rtl/stop_clk_gate.sv
module stop_clk_gate
    import stop_pkg::*;
(
    input  pwr_state_e        st,
    input  logic [STBY_W-1:0] stby,
    input  logic              main_pll_sel,
    input  logic              sub_pll_sel,
    output logic              main_osc_en,
    output logic              sub_osc_en,
    output logic              main_pll_en,
    output logic              sub_pll_en,
    output logic              pin_hiz,
    output logic              pin_hold
);
    logic in_stop;
    logic pins_ctl;

    always_comb begin
        in_stop  = (st == ST_STOP);
        pins_ctl = (st == ST_STOP) || (st == ST_WAKE);
        if (in_stop) begin
            main_osc_en = !stby[BIT_MAIN_OFF];
            sub_osc_en  = !stby[BIT_SUB_OFF];
            main_pll_en = !stby[BIT_MAIN_OFF] && main_pll_sel;
            sub_pll_en  = !stby[BIT_SUB_OFF] && sub_pll_sel;
        end else begin
            main_osc_en = 1'b1;
            sub_osc_en  = 1'b1;
            main_pll_en = main_pll_sel;
            sub_pll_en  = sub_pll_sel;
        end
        pin_hiz  = pins_ctl && stby[BIT_FLOAT];
        pin_hold = pins_ctl && !stby[BIT_FLOAT];
    end
endmodule

// File: rtl/stop_ctl.sv
module stop_ctl
    import stop_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int LW    = 5,
    parameter int CW    = 8,
    parameter int SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stby_wr,
    input  logic [7:0]          stby_wdata,
    output logic [7:0]          stby_rd,
    input  logic                main_pll_sel,
    input  logic                sub_pll_sel,
    input  logic [SEL_W-1:0]    clk_sel,
    input  logic                stop_req,
    input  logic [CW-1:0]       stab_cnt,
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic [N_EXT*LW-1:0] ext_lvl,
    input  logic                stab_irq,
    input  logic [LW-1:0]       stab_lvl,
    input  logic                watch_irq,
    input  logic [LW-1:0]       watch_lvl,
    input  logic                init_req,
    input  logic                rst_req,
    output logic [2:0]          state,
    output logic                run,
    output logic                main_osc_en,
    output logic                sub_osc_en,
    output logic                main_pll_en,
    output logic                sub_pll_en,
    output logic                pin_hiz,
    output logic                pin_hold,
    output logic                cfg_err
);
    localparam logic [SEL_W-1:0] SEL_DIV2 = '0;

    typedef struct packed {
        pwr_state_e        st;
        logic [STBY_W-1:0] stby;
        logic [CW-1:0]     cnt;
        logic              err;
    } ctl_t;

    ctl_t q_q;
    ctl_t n_d;

    logic wake;
    logic osc_was_off;

    stop_wake_eval #(.N_EXT(N_EXT), .LW(LW)) u_wake (
        .ext_irq      (ext_irq),
        .ext_lvl      (ext_lvl),
        .stab_irq     (stab_irq),
        .stab_lvl     (stab_lvl),
        .watch_irq    (watch_irq),
        .watch_lvl    (watch_lvl),
        .main_running (!q_q.stby[BIT_MAIN_OFF]),
        .sub_running  (!q_q.stby[BIT_SUB_OFF]),
        .wake         (wake)
    );

    stop_clk_gate u_gate (
        .st           (q_q.st),
        .stby         (q_q.stby),
        .main_pll_sel (main_pll_sel),
        .sub_pll_sel  (sub_pll_sel),
        .main_osc_en  (main_osc_en),
        .sub_osc_en   (sub_osc_en),
        .main_pll_en  (main_pll_en),
        .sub_pll_en   (sub_pll_en),
        .pin_hiz      (pin_hiz),
        .pin_hold     (pin_hold)
    );

    always_comb begin
        n_d         = q_q;
        osc_was_off = q_q.stby[BIT_MAIN_OFF] || q_q.stby[BIT_SUB_OFF];
        if (init_req) begin
            n_d.st   = ST_INIT;
            n_d.stby = '0;
            n_d.err  = 1'b0;
        end else if (rst_req) begin
            n_d.st = ST_RST;
        end else begin
            unique case (q_q.st)
                ST_RUN: begin
                    if (stby_wr) begin
                        n_d.stby = stby_wdata;
                    end
                    if (stop_req) begin
                        if (clk_sel == SEL_DIV2) begin
                            n_d.st = ST_STOP;
                        end else begin
                            n_d.err = 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (wake) begin
                        if (osc_was_off) begin
                            n_d.st  = ST_WAKE;
                            n_d.cnt = stab_cnt;
                        end else begin
                            n_d.st = ST_RUN;
                        end
                    end
                end
                ST_WAKE: begin
                    if (q_q.cnt == '0) begin
                        n_d.st = ST_RUN;
                    end else begin
                        n_d.cnt = q_q.cnt - 1'b1;
                    end
                end
                default: begin
                    n_d.st = ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_RUN, stby: '0, cnt: '0, err: 1'b0};
        end else begin
            q_q <= n_d;
        end
    end

    assign state   = q_q.st;
    assign run     = (q_q.st == ST_RUN);
    assign stby_rd = q_q.stby;
    assign cfg_err = q_q.err;
endmodule

// File: rtl/stop_ctl_chk.sv
module stop_ctl_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_req,
    input logic             rst_req,
    input logic             stop_req,
    input logic [SEL_W-1:0] clk_sel,
    input logic [2:0]       state,
    input logic             main_osc_en,
    input logic             sub_osc_en,
    input logic             main_pll_en,
    input logic             sub_pll_en,
    input logic             pin_hiz,
    input logic             pin_hold,
    input logic             cfg_err
);
    a_r5_main_pll_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd1 && main_pll_en) |-> main_osc_en);
    a_r5_sub_pll_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd1 && sub_pll_en) |-> sub_osc_en);
    a_r6_pin_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_hiz && pin_hold));
    a_r9_init_first: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (state == 3'd3));
    a_r9_rst_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_req && rst_req) |=> (state == 3'd4));
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !init_req) |=> cfg_err);
    a_r3_bad_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd0 && stop_req && clk_sel != '0 && !init_req && !rst_req)
        |=> (state == 3'd0 && cfg_err));
    a_r8_osc_on_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd2) |-> (main_osc_en && sub_osc_en));
endmodule

bind stop_ctl stop_ctl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .rst_req     (rst_req),
    .stop_req    (stop_req),
    .clk_sel     (clk_sel),
    .state       (state),
    .main_osc_en (main_osc_en),
    .sub_osc_en  (sub_osc_en),
    .main_pll_en (main_pll_en),
    .sub_pll_en  (sub_pll_en),
    .pin_hiz     (pin_hiz),
    .pin_hold    (pin_hold),
    .cfg_err     (cfg_err)
);

// File: tb/sim_stop_ctl.sv
`timescale 1ns/1ps
module sim_stop_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_wr = 1'b0;
    logic [7:0]  stby_wdata = '0;
    logic [7:0]  stby_rd;
    logic        main_pll_sel = 1'b0;
    logic        sub_pll_sel = 1'b0;
    logic [1:0]  clk_sel = '0;
    logic        stop_req = 1'b0;
    logic [7:0]  stab_cnt = '0;
    logic [3:0]  ext_irq = '0;
    logic [19:0] ext_lvl = '0;
    logic        stab_irq = 1'b0;
    logic [4:0]  stab_lvl = '0;
    logic        watch_irq = 1'b0;
    logic [4:0]  watch_lvl = '0;
    logic        init_req = 1'b0;
    logic        rst_req = 1'b0;
    logic [2:0]  state;
    logic        run, main_osc_en, sub_osc_en, main_pll_en, sub_pll_en;
    logic        pin_hiz, pin_hold, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int         m_st;
    logic [7:0] m_stby;
    int         m_cnt;
    logic       m_err;

    always #2 clk = ~clk;

    stop_ctl u0 (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_wake();
        bit w = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (ext_irq[i] && ext_lvl[i*5 +: 5] != 5'h1F) w = 1'b1;
        end
        if (stab_irq && !m_stby[0] && stab_lvl != 5'h1F) w = 1'b1;
        if (watch_irq && !m_stby[1] && watch_lvl != 5'h1F) w = 1'b1;
        return w;
    endfunction

    task automatic model_step();
        if (init_req) begin
            m_st = 3; m_stby = '0; m_err = 1'b0;
        end else if (rst_req) begin
            m_st = 4;
        end else begin
            case (m_st)
                0: begin
                    if (stby_wr) m_stby = stby_wdata;
                    if (stop_req) begin
                        if (clk_sel == 2'b00) m_st = 1;
                        else m_err = 1'b1;
                    end
                end
                1: if (model_wake()) begin
                    if (m_stby[0] || m_stby[1]) begin
                        m_st = 2; m_cnt = int'(stab_cnt);
                    end else m_st = 0;
                end
                2: if (m_cnt == 0) m_st = 0; else m_cnt--;
                default: m_st = 0;
            endcase
        end
    endtask

    task automatic compare_all();
        bit stp  = (m_st == 1);
        bit pins = (m_st == 1) || (m_st == 2);
        chk("R8 state", int'(state), m_st);
        chk("R8 run", int'(run), int'(m_st == 0));
        chk("R4 main_osc", int'(main_osc_en), stp ? int'(!m_stby[0]) : 1);
        chk("R4 sub_osc", int'(sub_osc_en), stp ? int'(!m_stby[1]) : 1);
        chk("R5 main_pll", int'(main_pll_en), stp ? int'(!m_stby[0] && main_pll_sel) : int'(main_pll_sel));
        chk("R5 sub_pll", int'(sub_pll_en), stp ? int'(!m_stby[1] && sub_pll_sel) : int'(sub_pll_sel));
        chk("R6 pin_hiz", int'(pin_hiz), int'(pins && m_stby[5]));
        chk("R6 pin_hold", int'(pin_hold), int'(pins && !m_stby[5]));
        chk("R3 cfg_err", int'(cfg_err), int'(m_err));
        chk("R11 stby_rd", int'(stby_rd), int'(m_stby));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        stby_wr = 0; stop_req = 0; ext_irq = '0; stab_irq = 0; watch_irq = 0;
        init_req = 0; rst_req = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd5150));
        m_st = 0; m_stby = '0; m_cnt = 0; m_err = 1'b0;
        main_pll_sel = 1; sub_pll_sel = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", int'(state), 0);
        chk("R1 run", int'(run), 1);
        chk("R1 osc", int'({main_osc_en, sub_osc_en}), 3);
        chk("R1 pll", int'({main_pll_en, sub_pll_en}), 3);
        chk("R1 pins", int'({pin_hiz, pin_hold}), 0);
        chk("R1 err", int'(cfg_err), 0);
        chk("R1 stby", int'(stby_rd), 0);

        // R3 wrong source refused
        clk_sel = 2'b01; stop_req = 1; tick(); quiet();
        chk("R3 stays run", int'(state), 0);
        chk("R3 err set", int'(cfg_err), 1);
        tick();
        chk("R3 err sticky", int'(cfg_err), 1);

        // R11 write main-off, hold pins; R2 entry
        clk_sel = 2'b00; stby_wr = 1; stby_wdata = 8'h01; tick(); quiet();
        stop_req = 1; tick(); quiet();
        chk("R2 entered stop", int'(state), 1);
        chk("R4 main osc off", int'(main_osc_en), 0);
        chk("R6 hold in stop", int'(pin_hold), 1);
        stby_wr = 1; stby_wdata = 8'hFF; tick(); quiet();
        chk("R11 write ignored in stop", int'(stby_rd), 8'h01);

        // R7 qualifications
        stab_irq = 1; stab_lvl = 5'd3; tick(); quiet();
        chk("R7 stab irq with main off", int'(state), 1);
        ext_irq = 4'b0100; ext_lvl = {20{1'b1}}; tick(); quiet();
        chk("R7 level 1F", int'(state), 1);
        watch_irq = 1; watch_lvl = 5'd7; stab_cnt = 8'd2; tick(); quiet();
        chk("R7 watch wakes", int'(state), 2);
        // R8 stabilization wait: cnt 2 -> 3 cycles in WAKE
        tick(); chk("R8 wake 2", int'(state), 2);
        tick(); chk("R8 wake 3", int'(state), 2);
        chk("R8 pins held in wake", int'(pin_hold), 1);
        tick(); chk("R8 run after wait", int'(state), 0);
        chk("R8 pins released", int'({pin_hiz, pin_hold}), 0);

        // R9 / R10 priority and INIT clearing
        init_req = 1; rst_req = 1; ext_irq = 4'b0001; ext_lvl = '0; tick();
        chk("R9 init wins", int'(state), 3);
        chk("R10 stby cleared", int'(stby_rd), 0);
        chk("R10 err cleared", int'(cfg_err), 0);
        init_req = 0; tick();
        chk("R9 rst second", int'(state), 4);
        quiet(); tick();
        chk("R10 rst exits to run", int'(state), 0);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            stby_wr      = ($urandom % 8) == 0;
            stby_wdata   = 8'($urandom);
            main_pll_sel = 1'($urandom);
            sub_pll_sel  = 1'($urandom);
            clk_sel      = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            stop_req     = ($urandom % 5) == 0;
            stab_cnt     = 8'($urandom % 6);
            ext_irq      = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
            for (int i = 0; i < 4; i++)
                ext_lvl[i*5 +: 5] = (($urandom % 2) == 0) ? 5'h1F : 5'($urandom);
            stab_irq     = ($urandom % 6) == 0;
            stab_lvl     = (($urandom % 2) == 0) ? 5'h1F : 5'($urandom % 31);
            watch_irq    = ($urandom % 6) == 0;
            watch_lvl    = (($urandom % 2) == 0) ? 5'h1F : 5'($urandom % 31);
            init_req     = ($urandom % 60) == 0;
            rst_req      = ($urandom % 50) == 0;
            tick();
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule